// File: doc/BRIEF.md
# Sparse Permutation Decomposition Engine

The engine accepts a square 0/1 matrix in which each row and each column carries exactly `K` ones, and splits it into `K` permutation matrices whose sum is the input. Software or an upstream block loads the nonzero entries as a list of `(row, column)` pairs through a write port, then pulses `start`. The list is walked once and every pair is given a permutation index, so all `K` permutations are built at the same time rather than extracted one after another.

Each pair first tries the lowest permutation index that is still unused at both its row and its column. A pair that finds none is set aside. A second sweep resolves the set-aside pairs by alternating-path rearrangement. It takes an index `a` unused at the row and an index `b` unused at the column, and walks from the column along edges coloured `a`, then `b`, then `a`, and so on. At every node on the way the two slots are exchanged, and the pair is then placed with index `a`. The occupancy tables have one slot per row and per index, and one per column and per index. This lets the walk move one node per clock.

When the run ends, a lookup port returns the column that a given permutation assigns to a given row. Inputs that cannot be decomposed raise `error` instead of `done`.

Top module: `perm_split_engine`

## Requirements
- R1: After reset `busy`, `done` and `error` are low, and every lookup returns `rd_hit` = 0.
- R2: A `start` pulse while idle clears all occupancy, `done` and `error`; in the following cycle `busy` is high and both flags are low.
- R3: For an input that obeys the K-ones rule, `done` rises and `error` stays low. Afterwards every (permutation, row) lookup has `rd_hit` = 1, and within each permutation every column is returned for exactly one row.
- R4: Summed over all permutations, the lookup results reproduce the loaded matrix entry for entry.
- R5: Inputs whose pair order leaves the first-fit pass stuck are still fully decomposed through alternating-path rearrangement.
- R6: If a row or column receives more than `K` pairs, `error` rises, `done` stays low and `busy` falls.
- R7: A `(row, column)` pair appearing twice in the list sets `error`.
- R8: A row or column value of `N` or more sets `error`.
- R9: After completion, `done` and the lookup results hold until the next `start`; writes to the pair list while idle do not alter them.
- R10: A valid input completes within `2*P + P*(2*N+2) + 4` cycles of `start`, where `P = N*K`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write one pair into the list (ignored while busy) |
| load_addr | input | $clog2(N*K) | List slot to write |
| load_row | input | $clog2(N) | Row of the pair |
| load_col | input | $clog2(N) | Column of the pair |
| start | input | 1 | Begin a decomposition run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished successfully |
| error | output | 1 | Input violates the K-ones rule or is malformed |
| rd_perm | input | $clog2(K) | Permutation index to look up |
| rd_row | input | $clog2(N) | Row to look up |
| rd_col | output | $clog2(N) | Column assigned to that row in that permutation |
| rd_hit | output | 1 | Lookup slot holds an assignment |

## Verification
The bench builds the engine with `N = 6` and `K = 3`, so each run involves 18 pairs and three-bit row and column fields. Those fields can carry the values 6 and 7, which makes the out-of-range check reachable. Three permutations also make it possible to order a list so that first-fit leaves a row and its column with disjoint free indices. The forward and reverse orderings of that list drive the rearrangement walk, and every result is checked as a complete permutation set whose sum is the input. An over-full row, a repeated pair and an out-of-range row each stop a run with `error`.

// File: rtl/perm_split_engine.sv
module perm_split_engine #(
  parameter int N = 4,
  parameter int K = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_en,
  input  logic [$clog2(N*K)-1:0] load_addr,
  input  logic [$clog2(N)-1:0]  load_row,
  input  logic [$clog2(N)-1:0]  load_col,
  input  logic                  start,
  output logic                  busy,
  output logic                  done,
  output logic                  error,
  input  logic [$clog2(K)-1:0]  rd_perm,
  input  logic [$clog2(N)-1:0]  rd_row,
  output logic [$clog2(N)-1:0]  rd_col,
  output logic                  rd_hit
);
  localparam int P  = N * K;
  localparam int RW = $clog2(N);
  localparam int KW = $clog2(K);
  localparam int AW = $clog2(P);
  localparam int CW = $clog2(P + 1);
  localparam int SW = $clog2(2 * N + 2);
  localparam logic [CW-1:0] PL = CW'(P);

  typedef enum logic [1:0] {S_IDLE, S_GREEDY, S_FIX, S_WALK} state_t;
  state_t st;

  logic [RW-1:0] pair_row [P];
  logic [RW-1:0] pair_col [P];
  logic          row_v [N][K];
  logic [RW-1:0] row_c [N][K];
  logic          col_v [N][K];
  logic [RW-1:0] col_r [N][K];
  logic [P-1:0]  defer;

  logic [CW-1:0] idx;
  logic [SW-1:0] steps;
  logic [RW-1:0] node;
  logic          on_col;
  logic [KW-1:0] ca, cb;

  function automatic logic [KW-1:0] first_one(input logic [K-1:0] m);
    first_one = '0;
    for (int i = K - 1; i >= 0; i--) if (m[i]) first_one = KW'(i);
  endfunction

  logic [AW-1:0] iw;
  logic [RW-1:0] cr, cc, crs, ccs;
  logic          oor, dup, bad, nxt_v, place;
  logic [K-1:0]  fr, fc, both;
  logic [RW-1:0] nxt;
  logic [KW-1:0] pick;

  assign iw  = (idx < PL) ? idx[AW-1:0] : '0;
  assign cr  = pair_row[iw];
  assign cc  = pair_col[iw];
  assign oor = (32'(cr) >= N) || (32'(cc) >= N);
  assign crs = oor ? '0 : cr;
  assign ccs = oor ? '0 : cc;

  always_comb begin
    dup = 1'b0;
    for (int p = 0; p < K; p++) begin
      fr[p] = !row_v[crs][p];
      fc[p] = !col_v[ccs][p];
      if (row_v[crs][p] && row_c[crs][p] == ccs) dup = 1'b1;
    end
  end

  assign both  = fr & fc;
  assign bad   = oor || ~|fr || ~|fc || dup;
  assign nxt_v = on_col ? col_v[node][ca] : row_v[node][cb];
  assign nxt   = on_col ? col_r[node][ca] : row_c[node][cb];
  assign pick  = (st == S_WALK) ? ca : first_one(both);
  assign place = (st == S_GREEDY && idx != PL && !bad && |both) ||
                 (st == S_FIX && idx != PL && defer[iw] && !bad && |both) ||
                 (st == S_WALK && !nxt_v);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      busy <= 1'b0;
      done <= 1'b0;
      error <= 1'b0;
      idx <= '0;
      steps <= '0;
      node <= '0;
      on_col <= 1'b0;
      ca <= '0;
      cb <= '0;
      defer <= '0;
      for (int r = 0; r < N; r++)
        for (int p = 0; p < K; p++) begin
          row_v[r][p] <= 1'b0;
          col_v[r][p] <= 1'b0;
        end
    end else begin
      if (load_en && !busy && 32'(load_addr) < P) begin
        pair_row[load_addr] <= load_row;
        pair_col[load_addr] <= load_col;
      end
      case (st)
        S_IDLE: if (start) begin
          for (int r = 0; r < N; r++)
            for (int p = 0; p < K; p++) begin
              row_v[r][p] <= 1'b0;
              col_v[r][p] <= 1'b0;
            end
          defer <= '0;
          idx <= '0;
          busy <= 1'b1;
          done <= 1'b0;
          error <= 1'b0;
          st <= S_GREEDY;
        end
        S_GREEDY: begin
          if (idx == PL) begin
            idx <= '0;
            st <= S_FIX;
          end else if (bad) begin
            error <= 1'b1;
            busy <= 1'b0;
            st <= S_IDLE;
          end else begin
            if (~|both) defer[iw] <= 1'b1;
            idx <= idx + CW'(1);
          end
        end
        S_FIX: begin
          if (idx == PL) begin
            done <= 1'b1;
            busy <= 1'b0;
            st <= S_IDLE;
          end else if (!defer[iw] || (!bad && |both)) begin
            idx <= idx + CW'(1);
          end else if (bad) begin
            error <= 1'b1;
            busy <= 1'b0;
            st <= S_IDLE;
          end else begin
            ca <= first_one(fr);
            cb <= first_one(fc);
            node <= ccs;
            on_col <= 1'b1;
            steps <= '0;
            st <= S_WALK;
          end
        end
        S_WALK: begin
          if (on_col) begin
            col_v[node][ca] <= col_v[node][cb];
            col_v[node][cb] <= col_v[node][ca];
            col_r[node][ca] <= col_r[node][cb];
            col_r[node][cb] <= col_r[node][ca];
          end else begin
            row_v[node][ca] <= row_v[node][cb];
            row_v[node][cb] <= row_v[node][ca];
            row_c[node][ca] <= row_c[node][cb];
            row_c[node][cb] <= row_c[node][ca];
          end
          steps <= steps + SW'(1);
          if (nxt_v) begin
            node <= nxt;
            on_col <= !on_col;
          end else begin
            idx <= idx + CW'(1);
            st <= S_FIX;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (place) begin
        row_v[crs][pick] <= 1'b1;
        row_c[crs][pick] <= ccs;
        col_v[ccs][pick] <= 1'b1;
        col_r[ccs][pick] <= crs;
      end
    end
  end

  logic          rd_ok;
  logic [RW-1:0] rrs;
  logic [KW-1:0] rps;
  assign rd_ok  = (32'(rd_row) < N) && (32'(rd_perm) < K);
  assign rrs    = rd_ok ? rd_row : '0;
  assign rps    = rd_ok ? rd_perm : '0;
  assign rd_hit = rd_ok && row_v[rrs][rps];
  assign rd_col = row_c[rrs][rps];

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && error)); // R6
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> (busy && !done && !error)); // R2
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> done); // R9
  AST_WALK_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (st == S_WALK) |-> (steps <= SW'(2 * N))); // R5
  AST_END_FLAG: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (done || error)); // R3
endmodule

// File: tb/perm_split_engine_tb.sv
module perm_split_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;
  localparam int K = 3;
  localparam int P = N * K;
  localparam int NV = 6;
  localparam int LIM = 2000;
  localparam int BOUND = 2 * P + P * (2 * N + 2) + 4;

  localparam logic [5:0] VEC [NV][P] = '{
    '{6'o00, 6'o01, 6'o12, 6'o23, 6'o24, 6'o22, 6'o02, 6'o13, 6'o14, 6'o30, 6'o31, 6'o35, 6'o43, 6'o44, 6'o45, 6'o50, 6'o51, 6'o55},
    '{6'o00, 6'o01, 6'o02, 6'o11, 6'o12, 6'o13, 6'o22, 6'o23, 6'o24, 6'o33, 6'o34, 6'o35, 6'o44, 6'o45, 6'o40, 6'o55, 6'o50, 6'o51},
    '{6'o00, 6'o01, 6'o02, 6'o11, 6'o12, 6'o13, 6'o22, 6'o23, 6'o24, 6'o33, 6'o34, 6'o35, 6'o44, 6'o45, 6'o40, 6'o55, 6'o50, 6'o03},
    '{6'o00, 6'o00, 6'o02, 6'o11, 6'o12, 6'o13, 6'o22, 6'o23, 6'o24, 6'o33, 6'o34, 6'o35, 6'o44, 6'o45, 6'o40, 6'o55, 6'o51, 6'o51},
    '{6'o60, 6'o01, 6'o02, 6'o11, 6'o12, 6'o13, 6'o22, 6'o23, 6'o24, 6'o33, 6'o34, 6'o35, 6'o44, 6'o45, 6'o40, 6'o55, 6'o50, 6'o51},
    '{6'o55, 6'o51, 6'o50, 6'o45, 6'o44, 6'o43, 6'o35, 6'o31, 6'o30, 6'o14, 6'o13, 6'o02, 6'o22, 6'o24, 6'o23, 6'o12, 6'o01, 6'o00}
  };
  localparam bit VEC_ERR [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam string VEC_REQ [NV] = '{"R5", "R3", "R6", "R7", "R8", "R5"};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_en = 1'b0;
  logic [4:0] load_addr = '0;
  logic [2:0] load_row = '0, load_col = '0;
  logic       start = 1'b0;
  logic       busy, done, error;
  logic [1:0] rd_perm = '0;
  logic [2:0] rd_row = '0;
  logic [2:0] rd_col;
  logic       rd_hit;

  int tests = 0;
  int fails = 0;
  int got [K][N];
  int wd = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  perm_split_engine #(.N(N), .K(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_row(load_row), .load_col(load_col), .start(start), .busy(busy),
    .done(done), .error(error), .rd_perm(rd_perm), .rd_row(rd_row),
    .rd_col(rd_col), .rd_hit(rd_hit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input int p, input int r, output int col, output int hit);
    @(negedge clk);
    rd_perm = 2'(p);
    rd_row = 3'(r);
    #1;
    col = int'(rd_col);
    hit = int'(rd_hit);
  endtask

  task automatic run_vec(input int v);
    int cyc, col, hit;
    int exp [N][N];
    int sum [N][N];
    int seen [N];
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      load_en = 1'b1;
      load_addr = 5'(i);
      load_row = VEC[v][i][5:3];
      load_col = VEC[v][i][2:0];
    end
    @(negedge clk);
    load_en = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && !error, "R2", int'({busy, done, error}), 4);
    cyc = 1;
    while (!(done || error) && cyc < LIM) begin
      @(negedge clk);
      cyc++;
    end
    if (VEC_ERR[v]) begin
      chk(error && !done && !busy, VEC_REQ[v], int'({busy, done, error}), 1);
      return;
    end
    chk(done && !error && !busy, "R3", int'({busy, done, error}), 2);
    chk(cyc <= BOUND, "R10", cyc, BOUND);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        exp[r][c] = 0;
        sum[r][c] = 0;
      end
    for (int i = 0; i < P; i++) exp[VEC[v][i][5:3]][VEC[v][i][2:0]]++;
    for (int p = 0; p < K; p++) begin
      for (int c = 0; c < N; c++) seen[c] = 0;
      for (int r = 0; r < N; r++) begin
        rd(p, r, col, hit);
        got[p][r] = col;
        chk(hit == 1 && col < N, "R3", hit * 8 + col, 8);
        if (col < N) begin
          seen[col]++;
          sum[r][col]++;
        end
      end
      for (int c = 0; c < N; c++) chk(seen[c] == 1, "R3", seen[c], 1);
    end
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        chk(sum[r][c] == exp[r][c], v == 1 ? "R4" : "R5", sum[r][c], exp[r][c]);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int col, hit;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !error, "R1", int'({busy, done, error}), 0);
    for (int p = 0; p < K; p++) begin
      rd(p, p + 1, col, hit);
      chk(hit == 0, "R1", hit, 0);
    end

    for (int v = 0; v < NV; v++) run_vec(v);

    repeat (20) @(negedge clk);
    chk(done && !error, "R9", int'({done, error}), 2);
    @(negedge clk);
    load_en = 1'b1;
    load_addr = 5'd0;
    load_row = 3'd2;
    load_col = 3'd5;
    @(negedge clk);
    load_en = 1'b0;
    for (int p = 0; p < K; p++) begin
      rd(p, 0, col, hit);
      chk(hit == 1 && col == got[p][0], "R9", col, got[p][0]);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule